// File: doc/BRIEF.md
# Utility Bus Chip-Select Decoder

This block watches host cycles and works out which peripheral on a utility bus they address: the boot ROM windows in memory space, or the floppy controller and IDE drive ports in I/O space. For each addressed device it puts a 3-bit encoded chip select on its output, drops an active-low enable for the utility-bus data transceiver, and for the floppy controller also drops a dedicated active-low select. An external decoder expands the 3-bit code into individual selects.

An 8-bit configuration register sets the behaviour. Individual bits enable each memory window and each port group, and one bit picks which of two port banks (primary or secondary) the floppy and IDE decoders answer to. Software reads and writes the register through a plain strobe port. The decode path is combinational from the cycle inputs and the current register value. It has no handshake, so it never applies back-pressure. A cycle counts only while `cyc_valid` is high.

Top module: `ubus_csel_dec`

## Requirements
- R1: After reset the configuration register reads 07h: both BIOS windows, the IDE decode and the low floppy ports are disabled, the high floppy ports are enabled, and the primary bank is selected.
- R2: A write with `cfg_wr` high loads all 8 bits of `cfg_wdata` at the clock edge. From the next cycle the new value reads back on `cfg_rdata` and controls the decode.
- R3: With bit 7 set, a valid memory cycle to FFF80000h–FFFDFFFFh gives code 000 (BIOS) and a low `xcvr_oe_n`. With bit 7 clear, that range stays idle.
- R4: With bit 6 set, a valid memory cycle to 000E0000h–000EFFFFh, FFEE0000h–FFEEFFFFh or FFFE0000h–FFFEFFFFh gives code 000. Nearby addresses outside these windows stay idle.
- R5: With bit 4 set, a valid I/O cycle to the IDE command ports gives code 010. These ports are 1F0h–1F7h in the primary bank and 170h–177h in the secondary bank.
- R6: With bit 4 set, the IDE control ports of the selected bank give code 011 and leave `fdc_cs_n` high, even where a floppy range covers them. These ports are 3F6h–3F7h (primary) and 376h–377h (secondary). With bit 4 clear, these ports decode as floppy ports when a floppy range covers them.
- R7: Bit 3 enables the low floppy ports: 3F0h–3F1h (primary) or 370h–371h (secondary). Bit 2 enables the high floppy ports: 3F2h–3F7h (primary) or 372h–37Fh (secondary). A floppy hit gives code 100 and drives `fdc_cs_n` low.
- R8: Bit 5 picks the bank (0 primary, 1 secondary). Ports of the bank that is not selected stay idle.
- R9: While `fdc_present` is 0, no floppy port decodes: the code stays at 111 and `fdc_cs_n` stays high.
- R10: While `cyc_valid` is 0, all outputs are idle (code 111, both active-low outputs high). `xcvr_oe_n` is low exactly when the code is not 111.
- R11: `cyc_is_io` picks which address is decoded: memory cycles never produce I/O device codes, and I/O cycles never produce the BIOS code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents |
| cyc_valid | input | 1 | Host cycle present |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| mem_addr | input | 32 | Memory cycle address |
| io_addr | input | 16 | I/O cycle address |
| fdc_present | input | 1 | Floppy controller fitted |
| csel_code | output | 3 | Encoded chip select, 111 = none |
| fdc_cs_n | output | 1 | Floppy select, active low |
| xcvr_oe_n | output | 1 | Utility-bus transceiver enable, active low |

## Verification
The assertions check the output invariants on every cycle: idle outputs outside valid cycles, a transceiver enable that agrees with the code, a floppy select only together with code 100 and never while the controller is absent, and no BIOS code in an I/O cycle. They also check that every write shows up on the readback one cycle later. Only the bench scenarios can show that each window has the right bounds and that bank switching works. They also show that the IDE control ports beat the floppy range, and that this override goes away when IDE decode is turned off.

// File: rtl/ubus_csel_pkg.sv
package ubus_csel_pkg;
  typedef enum logic [2:0] {
    SEL_BIOS    = 3'b000,
    SEL_IDE_CMD = 3'b010,
    SEL_IDE_CTL = 3'b011,
    SEL_FDC     = 3'b100,
    SEL_NONE    = 3'b111
  } csel_e;

  localparam int CFG_W = 8;
  localparam int B_EXT_BIOS = 7;
  localparam int B_LOW_BIOS = 6;
  localparam int B_BANK_SEC = 5;
  localparam int B_IDE_EN   = 4;
  localparam int B_FDC_LO   = 3;
  localparam int B_FDC_HI   = 2;
endpackage

// File: rtl/ubus_cfg_reg.sv
module ubus_cfg_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/ubus_mem_dec.sv
module ubus_mem_dec #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          ext_en,
  input  logic          low_en,
  output logic          hit
);
  localparam logic [AW-1:0] EXT_LO = AW'(32'hFFF8_0000);
  localparam logic [AW-1:0] EXT_HI = AW'(32'hFFFD_FFFF);
  localparam int BLK_SH = 16;
  localparam int TAG_W  = AW - BLK_SH;
  localparam int N_WIN  = 3;
  localparam logic [N_WIN*TAG_W-1:0] WIN_TAGS =
    {TAG_W'(16'h000E), TAG_W'(16'hFFEE), TAG_W'(16'hFFFE)};

  logic [N_WIN-1:0] win_hit;
  logic ext_hit;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    assign win_hit[g] = (addr[AW-1:BLK_SH] == WIN_TAGS[g*TAG_W +: TAG_W]);
  end

  assign ext_hit = (addr >= EXT_LO) && (addr <= EXT_HI);
  assign hit = (ext_en && ext_hit) || (low_en && (|win_hit));
endmodule

// File: rtl/ubus_io_dec.sv
module ubus_io_dec #(
  parameter int IW = 16
) (
  input  logic [IW-1:0] addr,
  input  logic          bank_sec,
  input  logic          ide_en,
  input  logic          fdc_lo_en,
  input  logic          fdc_hi_en,
  input  logic          fdc_present,
  output logic          ide_cmd_hit,
  output logic          ide_ctl_hit,
  output logic          fdc_hit
);
  localparam logic [IW-1:0] FDC_BASE_P = IW'(16'h03F0);
  localparam logic [IW-1:0] FDC_BASE_S = IW'(16'h0370);
  localparam logic [IW-1:0] FDC_TOP_P  = IW'(16'h03F7);
  localparam logic [IW-1:0] FDC_TOP_S  = IW'(16'h037F);
  localparam logic [IW-1:0] CMD_BASE_P = IW'(16'h01F0);
  localparam logic [IW-1:0] CMD_BASE_S = IW'(16'h0170);
  localparam logic [IW-1:0] CTL_OFS    = IW'(6);
  localparam logic [IW-1:0] HI_OFS     = IW'(2);

  logic [IW-1:0] fbase, ftop, cbase, ctl_port, hi_start;
  logic lo_rng, hi_rng;

  always_comb begin
    fbase    = bank_sec ? FDC_BASE_S : FDC_BASE_P;
    ftop     = bank_sec ? FDC_TOP_S  : FDC_TOP_P;
    cbase    = bank_sec ? CMD_BASE_S : CMD_BASE_P;
    ctl_port = fbase + CTL_OFS;
    hi_start = fbase + HI_OFS;
  end

  assign ide_cmd_hit = ide_en && (addr[IW-1:3] == cbase[IW-1:3]);
  assign ide_ctl_hit = ide_en && (addr[IW-1:1] == ctl_port[IW-1:1]);
  assign lo_rng      = (addr[IW-1:1] == fbase[IW-1:1]);
  assign hi_rng      = (addr >= hi_start) && (addr <= ftop);
  assign fdc_hit     = fdc_present && !ide_ctl_hit &&
                       ((fdc_lo_en && lo_rng) || (fdc_hi_en && hi_rng));
endmodule

// File: rtl/ubus_csel_dec.sv
module ubus_csel_dec
  import ubus_csel_pkg::*;
#(
  parameter int MEM_AW = 32,
  parameter int IO_AW  = 16,
  parameter logic [CFG_W-1:0] CFG_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              cyc_valid,
  input  logic              cyc_is_io,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              fdc_present,
  output logic [2:0]        csel_code,
  output logic              fdc_cs_n,
  output logic              xcvr_oe_n
);
  logic [CFG_W-1:0] cfg;
  logic bios_hit, cmd_hit, ctl_hit, flp_hit;
  csel_e sel;

  ubus_cfg_reg #(.W(CFG_W), .RST_VAL(CFG_RST)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .q(cfg)
  );

  ubus_mem_dec #(.AW(MEM_AW)) i_mem (
    .addr(mem_addr), .ext_en(cfg[B_EXT_BIOS]), .low_en(cfg[B_LOW_BIOS]),
    .hit(bios_hit)
  );

  ubus_io_dec #(.IW(IO_AW)) i_io (
    .addr(io_addr), .bank_sec(cfg[B_BANK_SEC]), .ide_en(cfg[B_IDE_EN]),
    .fdc_lo_en(cfg[B_FDC_LO]), .fdc_hi_en(cfg[B_FDC_HI]),
    .fdc_present(fdc_present), .ide_cmd_hit(cmd_hit),
    .ide_ctl_hit(ctl_hit), .fdc_hit(flp_hit)
  );

  always_comb begin
    sel = SEL_NONE;
    if (cyc_valid) begin
      if (!cyc_is_io) begin
        if (bios_hit) sel = SEL_BIOS;
      end else if (ctl_hit) sel = SEL_IDE_CTL;
      else if (cmd_hit)     sel = SEL_IDE_CMD;
      else if (flp_hit)     sel = SEL_FDC;
    end
  end

  assign cfg_rdata = cfg;
  assign csel_code = sel;
  assign fdc_cs_n  = (sel != SEL_FDC);
  assign xcvr_oe_n = (sel == SEL_NONE);
endmodule

// File: rtl/ubus_csel_chk.sv
module ubus_csel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic        cyc_valid,
  input logic        cyc_is_io,
  input logic        fdc_present,
  input logic [2:0]  csel_code,
  input logic        fdc_cs_n,
  input logic        xcvr_oe_n
);
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata)); // R2
  AST_FDC_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_present |-> fdc_cs_n); // R9
  AST_FDC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_cs_n |-> csel_code == 3'b100); // R7
  AST_IDLE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> (csel_code == 3'b111 && fdc_cs_n && xcvr_oe_n)); // R10
  AST_OE_WITH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (csel_code != 3'b111) |-> !xcvr_oe_n); // R10
  AST_IO_NO_BIOS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_is_io) |-> csel_code != 3'b000); // R11
endmodule

bind ubus_csel_dec ubus_csel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid), .cyc_is_io(cyc_is_io),
  .fdc_present(fdc_present), .csel_code(csel_code), .fdc_cs_n(fdc_cs_n),
  .xcvr_oe_n(xcvr_oe_n)
);

// File: tb/test_ubus_csel_dec.sv
module test_ubus_csel_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic        cyc_is_io = 1'b0;
  logic [31:0] mem_addr = 32'h0;
  logic [15:0] io_addr = 16'h0;
  logic        fdc_present = 1'b1;
  logic [2:0]  csel_code;
  logic        fdc_cs_n;
  logic        xcvr_oe_n;
  int checks = 0;
  int fails = 0;

  localparam logic [2:0] C_BIOS = 3'b000, C_CMD = 3'b010, C_CTL = 3'b011,
                         C_FDC = 3'b100, C_NONE = 3'b111;

  always #10 clk = ~clk;

  ubus_csel_dec i_ubus_csel_dec (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid), .cyc_is_io(cyc_is_io),
    .mem_addr(mem_addr), .io_addr(io_addr), .fdc_present(fdc_present),
    .csel_code(csel_code), .fdc_cs_n(fdc_cs_n), .xcvr_oe_n(xcvr_oe_n)
  );

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic expect_out(string req, logic [2:0] code);
    logic exp_f, exp_o;
    exp_f = (code != C_FDC);
    exp_o = (code == C_NONE);
    checks++;
    if (csel_code !== code || fdc_cs_n !== exp_f || xcvr_oe_n !== exp_o) begin
      fails++;
      $display("FAIL %s: got code=%b fdc_n=%b oe_n=%b, expected code=%b fdc_n=%b oe_n=%b",
               req, csel_code, fdc_cs_n, xcvr_oe_n, code, exp_f, exp_o);
    end
  endtask

  task automatic expect_reg(string req, logic [7:0] v);
    checks++;
    if (cfg_rdata !== v) begin
      fails++;
      $display("FAIL %s: got cfg=%h expected %h", req, cfg_rdata, v);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = ~v;
  endtask

  task automatic mem_cyc(string req, logic [31:0] a, logic [2:0] code);
    @(negedge clk); cyc_valid = 1'b1; cyc_is_io = 1'b0; mem_addr = a;
    #2 expect_out(req, code);
  endtask

  task automatic io_cyc(string req, logic [15:0] a, logic [2:0] code);
    @(negedge clk); cyc_valid = 1'b1; cyc_is_io = 1'b1; io_addr = a;
    #2 expect_out(req, code);
  endtask

  task automatic t_reset();
    expect_reg("R1 reset value", 8'h07);
    io_cyc("R1 high floppy on", 16'h03F2, C_FDC);
    io_cyc("R1 low floppy off", 16'h03F0, C_NONE);
    io_cyc("R1 ide off", 16'h01F0, C_NONE);
    io_cyc("R6 ctl as floppy when ide off", 16'h03F7, C_FDC);
    mem_cyc("R1 bios off", 32'h000E_0000, C_NONE);
  endtask

  task automatic t_primary();
    write_cfg(8'hDC);
    expect_reg("R2 readback", 8'hDC);
    mem_cyc("R3 ext low", 32'hFFF8_0000, C_BIOS);
    mem_cyc("R3 ext high", 32'hFFFD_FFFF, C_BIOS);
    mem_cyc("R4 top alias", 32'hFFFE_0000, C_BIOS);
    mem_cyc("R4 mid alias", 32'hFFEE_1234, C_BIOS);
    mem_cyc("R4 low block", 32'h000E_FFFF, C_BIOS);
    mem_cyc("R4 above block", 32'h000F_0000, C_NONE);
    mem_cyc("R4 top of 4G", 32'hFFFF_0000, C_NONE);
    io_cyc("R5 cmd first", 16'h01F0, C_CMD);
    io_cyc("R5 cmd last", 16'h01F7, C_CMD);
    io_cyc("R5 cmd past", 16'h01F8, C_NONE);
    io_cyc("R6 ctl override", 16'h03F6, C_CTL);
    io_cyc("R7 low floppy", 16'h03F1, C_FDC);
    io_cyc("R7 high floppy", 16'h03F5, C_FDC);
    io_cyc("R8 other bank", 16'h0372, C_NONE);
    io_cyc("R7 past high", 16'h03F8, C_NONE);
    @(negedge clk); cyc_is_io = 1'b0; mem_addr = 32'h0; io_addr = 16'h03F0;
    #2 expect_out("R11 mem ignores io addr", C_NONE);
    @(negedge clk); cyc_is_io = 1'b1; mem_addr = 32'hFFF8_0000; io_addr = 16'h0000;
    #2 expect_out("R11 io ignores mem addr", C_NONE);
    @(negedge clk); cyc_valid = 1'b0; io_addr = 16'h03F0;
    #2 expect_out("R10 invalid idle", C_NONE);
    @(negedge clk); cyc_valid = 1'b1; fdc_present = 1'b0;
    #2 expect_out("R9 absent low", C_NONE);
    io_addr = 16'h03F4;
    #2 expect_out("R9 absent high", C_NONE);
    fdc_present = 1'b1;
  endtask

  task automatic t_secondary();
    write_cfg(8'hFC);
    expect_reg("R2 readback sec", 8'hFC);
    io_cyc("R5 sec cmd", 16'h0170, C_CMD);
    io_cyc("R6 sec ctl", 16'h0377, C_CTL);
    io_cyc("R7 sec low", 16'h0370, C_FDC);
    io_cyc("R7 sec high", 16'h0372, C_FDC);
    io_cyc("R7 sec top", 16'h037F, C_FDC);
    io_cyc("R8 primary floppy idle", 16'h03F0, C_NONE);
    io_cyc("R8 primary ide idle", 16'h01F0, C_NONE);
    write_cfg(8'h2C);
    io_cyc("R6 sec ctl as floppy", 16'h0376, C_FDC);
    write_cfg(8'h00);
    expect_reg("R2 clear", 8'h00);
    mem_cyc("R3 ext disabled", 32'hFFF8_0000, C_NONE);
    io_cyc("R7 all floppy off", 16'h03F2, C_NONE);
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_secondary();
    @(negedge clk); cyc_valid = 1'b0;
    summary();
  end
endmodule